// File: doc/BRIEF.md
# Configurable-Direction Ripple Counter

This block is an n-stage asynchronous binary counter built from a chain of divide-by-two toggle stages. Only the lowest stage sees the external clock. Every higher stage is clocked by a signal taken from the stage just below it, so each stage runs at half the rate of its neighbour. A change therefore travels up the chain one stage at a time, and the count is valid only once that ripple has settled.

Three build-time polarity choices shape the chain. The first sets the edge that every stage toggles on. The second sets whether a stage is clocked from the true or the inverted state of the stage below. The third sets whether the count is read from the true or the inverted states. There is no direction input. The direction comes from the parity of these three choices, so changing any odd number of them reverses the count. An active-high sanity input clears every stage to zero at once, whether or not the clock is running.

Top module: `ripple_counter`

## Requirements
- R1: While `sanity_i` is 1, every stage state is 0. This takes effect asynchronously, without waiting for a clock edge, and holds for as long as the input stays high, whatever the clock does.
- R2: Stage 0 toggles exactly once per input clock period. It toggles on the rising edge of `clk_i` when `RISE_EDGE` is 1 and on the falling edge when it is 0. The other edge leaves the count unchanged.
- R3: Stage k (k ≥ 1) toggles only when its trigger signal makes the selected transition. That trigger is the state of stage k−1 when `TRIG_TRUE` is 1 and its inverse when `TRIG_TRUE` is 0. Stage k therefore runs at the clock rate divided by 2^(k+1).
- R4: The count runs down when `RISE_EDGE ^ TRIG_TRUE ^ READ_TRUE` is 1 and up when it is 0. Once settled, each active clock edge changes `count_o` by exactly −1 or +1 modulo 2^N_STAGES, in that direction.
- R5: When `READ_TRUE` is 0, `count_o` is the bitwise inverse of the stage states, so it reads all ones while cleared. When `READ_TRUE` is 1, `count_o` equals the stage states and reads 0 while cleared.
- R6: With the default parameters (falling edge, trigger from the true state, read from the true state), the count goes 0, 1, 2, … after the clear is released, advancing on each falling edge of `clk_i`.
- R7: The count wraps. An up count goes from 2^N_STAGES−1 to 0, a down count goes from 0 to 2^N_STAGES−1, and after 2^N_STAGES active edges the count is back at its cleared value.
- R8: A clear asserted in the middle of a count overrides any toggling. After release, counting restarts from the cleared value on the next active edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | External count clock, drives stage 0 only |
| sanity_i | input | 1 | Asynchronous active-high clear of all stages |
| count_o | output | N_STAGES | Count read from the stage states in the selected polarity |

## Verification
A stage that toggles on the wrong edge, or that takes the wrong trigger polarity, breaks the ±1 step at the very next active edge. An up count becomes a down count, or the count jumps by a power of two, within one clock period. A wrong read polarity or a faulty clear shows as a wrong cleared value within nanoseconds of asserting `sanity_i`, with no clock edge needed. A fault in a high stage can hide until the low stages carry into it, so the runs go through full wraps of 2^N_STAGES edges in all eight polarity combinations.

// File: rtl/ripple_pkg.sv
// Package: shared helpers for the ripple counter.
// Assumes: polarity choices are single bits fixed at build time.
package ripple_pkg;

    // Count direction from the three polarity choices: 1 = down, 0 = up.
    function automatic bit count_is_down(input bit rise_edge, input bit trig_true, input bit read_true);
        return rise_edge ^ trig_true ^ read_true;
    endfunction

    // Direction of the raw stage states, which are always read true.
    function automatic bit state_is_down(input bit rise_edge, input bit trig_true);
        return rise_edge ^ trig_true ^ 1'b1;
    endfunction

endpackage

// File: rtl/ripple_toggle_stage.sv
// Module: one divide-by-two toggle element of the ripple chain.
// Toggles on the selected edge of its own trigger input. An active-high
// asynchronous clear forces the state to 0 and overrides toggling.
// Assumes: the trigger is a clean, glitch-free clock-like signal.
module ripple_toggle_stage #(
    parameter bit RISE_EDGE = 1'b0
) (
    input  logic trig_i,
    input  logic clr_i,
    output logic q_o
);

    generate
        if (RISE_EDGE) begin : g_rise
            // Toggle on the rising trigger edge, clear asynchronously.
            always_ff @(posedge trig_i or posedge clr_i) begin
                if (clr_i) q_o <= 1'b0;
                else       q_o <= ~q_o;
            end
        end else begin : g_fall
            // Toggle on the falling trigger edge, clear asynchronously.
            always_ff @(negedge trig_i or posedge clr_i) begin
                if (clr_i) q_o <= 1'b0;
                else       q_o <= ~q_o;
            end
        end
    endgenerate

endmodule

// File: rtl/ripple_stage_chain.sv
// Module: the chain of toggle stages. Stage 0 is clocked by clk_i and
// stage k by the true or inverted state of stage k-1.
// Also keeps a small post-clear edge counter that qualifies the chain's
// step assertions.
// Assumes: the checks sample once per clk_i period, after the ripple has settled.
module ripple_stage_chain
    import ripple_pkg::*;
#(
    parameter int N_STAGES  = 4,
    parameter bit RISE_EDGE = 1'b0,
    parameter bit TRIG_TRUE = 1'b1
) (
    input  logic                clk_i,
    input  logic                clr_i,
    output logic [N_STAGES-1:0] state_o,
    output logic                armed_o
);

    localparam bit                RAW_DOWN = state_is_down(RISE_EDGE, TRIG_TRUE);
    localparam logic [N_STAGES-1:0] RAW_STEP = RAW_DOWN ? {N_STAGES{1'b1}} : N_STAGES'(1);

    logic [N_STAGES-1:0] trig;
    logic [1:0]          edges_seen;

    assign trig[0] = clk_i;

    generate
        for (genvar k = 1; k < N_STAGES; k++) begin : g_trig
            if (TRIG_TRUE) begin : g_true
                assign trig[k] = state_o[k-1];
            end else begin : g_inv
                assign trig[k] = ~state_o[k-1];
            end
        end

        for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
            ripple_toggle_stage #(
                .RISE_EDGE(RISE_EDGE)
            ) u_stage (
                .trig_i(trig[k]),
                .clr_i (clr_i),
                .q_o   (state_o[k])
            );
        end
    endgenerate

    // Count rising clk_i edges since the clear was released, saturating at 2.
    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i)                 edges_seen <= 2'd0;
        else if (edges_seen != 2'd2) edges_seen <= edges_seen + 2'd1;
    end

    assign armed_o = (edges_seen == 2'd2);

    // R2: the LSB changes once between consecutive settled samples.
    a_r2_lsb_toggles: assert property (@(posedge clk_i) disable iff (clr_i)
        armed_o |-> (state_o[0] != $past(state_o[0])));

    // R3: the raw states step by one in the direction set by edge and trigger.
    a_r3_state_step: assert property (@(posedge clk_i) disable iff (clr_i)
        armed_o |-> ((state_o - $past(state_o)) == RAW_STEP));

    generate
        for (genvar k = 1; k < N_STAGES; k++) begin : g_chk
            // R3: a higher stage changes only when the stage below it changed.
            a_r3_ripple_cause: assert property (@(posedge clk_i) disable iff (clr_i)
                (armed_o && (state_o[k] != $past(state_o[k]))) |-> (state_o[k-1] != $past(state_o[k-1])));
        end
    endgenerate

endmodule

// File: rtl/ripple_count_view.sv
// Module: presents the stage states as the count in the selected read polarity.
// Assumes: purely combinational; the ripple settling is the caller's concern.
module ripple_count_view #(
    parameter int N_STAGES  = 4,
    parameter bit READ_TRUE = 1'b1
) (
    input  logic [N_STAGES-1:0] state_i,
    output logic [N_STAGES-1:0] count_o
);

    generate
        if (READ_TRUE) begin : g_true
            assign count_o = state_i;
        end else begin : g_inv
            assign count_o = ~state_i;
        end
    endgenerate

endmodule

// File: rtl/ripple_counter.sv
// Module: top of the configurable-direction ripple counter.
// The direction follows from the parity of RISE_EDGE, TRIG_TRUE and READ_TRUE.
// sanity_i clears every stage asynchronously and is active high.
// Assumes: count_o is sampled only after the ripple has settled.
module ripple_counter
    import ripple_pkg::*;
#(
    parameter int N_STAGES  = 4,
    parameter bit RISE_EDGE = 1'b0,
    parameter bit TRIG_TRUE = 1'b1,
    parameter bit READ_TRUE = 1'b1
) (
    input  logic                clk_i,
    input  logic                sanity_i,
    output logic [N_STAGES-1:0] count_o
);

    localparam bit                COUNT_DOWN = count_is_down(RISE_EDGE, TRIG_TRUE, READ_TRUE);
    localparam logic [N_STAGES-1:0] STEP     = COUNT_DOWN ? {N_STAGES{1'b1}} : N_STAGES'(1);

    logic [N_STAGES-1:0] state;
    logic                armed;

    ripple_stage_chain #(
        .N_STAGES (N_STAGES),
        .RISE_EDGE(RISE_EDGE),
        .TRIG_TRUE(TRIG_TRUE)
    ) u_chain (
        .clk_i  (clk_i),
        .clr_i  (sanity_i),
        .state_o(state),
        .armed_o(armed)
    );

    ripple_count_view #(
        .N_STAGES (N_STAGES),
        .READ_TRUE(READ_TRUE)
    ) u_view (
        .state_i(state),
        .count_o(count_o)
    );

    // R4: the visible count steps by exactly one in the parity-derived direction.
    a_r4_count_step: assert property (@(posedge clk_i) disable iff (sanity_i)
        armed |-> ((count_o - $past(count_o)) == STEP));

endmodule

// File: tb/sim_ripple_counter.sv
// Bench: all eight polarity builds run side by side from one clock and clear.
module sim_ripple_counter;

    localparam int N = 4;
    localparam int NCFG = 8;

    logic         clk;
    logic         sanity;
    logic [N-1:0] cnt [NCFG];

    int vectors = 0;
    int errors  = 0;
    int nr = 0;
    int nf = 0;
    bit done = 0;

    // Config index g: bit 2 = rising edge, bit 1 = trigger true, bit 0 = read true.
    generate
        for (genvar g = 0; g < NCFG; g++) begin : g_cfg
            ripple_counter #(
                .N_STAGES (N),
                .RISE_EDGE(bit'((g / 4) % 2)),
                .TRIG_TRUE(bit'((g / 2) % 2)),
                .READ_TRUE(bit'(g % 2))
            ) u0 (
                .clk_i   (clk),
                .sanity_i(sanity),
                .count_o (cnt[g])
            );
        end
    endgenerate

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    function automatic logic [N-1:0] expect_count(int g, int steps);
        bit r  = g[2];
        bit t  = g[1];
        bit rd = g[0];
        bit down = r ^ t ^ rd;
        logic [N-1:0] base = rd ? '0 : '1;
        logic [N-1:0] s = N'(steps);
        return down ? base - s : base + s;
    endfunction

    task automatic check(string req, int g, logic [N-1:0] exp);
        vectors++;
        if (cnt[g] !== exp) begin
            errors++;
            $display("FAIL %s cfg=%0d actual=%0h expected=%0h t=%0t", req, g, cnt[g], exp, $time);
        end
    endtask

    // R2 R3 R4: every build matches its own edge count and direction.
    task automatic check_all();
        for (int g = 0; g < NCFG; g++)
            check("R2 R3 R4", g, expect_count(g, g[2] ? nr : nf));
    endtask

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); nr++; #2; check_all();
            @(negedge clk); nf++; #2; check_all();
        end
    endtask

    task automatic release_clear();
        @(negedge clk); #2.5;
        sanity = 1'b0;
        nr = 0; nf = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        sanity = 1'b1;
        #2;
        // R1 R5: cleared value per read polarity.
        for (int g = 0; g < NCFG; g++) check("R1 R5", g, g[0] ? '0 : '1);

        release_clear();
        // R6: default build (cfg 3) counts 0,1,2,3 on falling edges.
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk); #2; nf++; nr++;
            check("R6", 3, N'(i));
        end
        // R4 R7: rising-edge build with other defaults (cfg 7) counts down through the wrap.
        check("R4 R7", 7, N'(16 - 3));
        run_cycles(13);
        // R7: after 2^N active edges every build is back at its cleared value.
        for (int g = 0; g < NCFG; g++) check("R7", g, g[0] ? '0 : '1);
        run_cycles(20);

        // R1 R8: random mid-count clears, asserted and released away from clock edges.
        for (int iter = 0; iter < 30; iter++) begin
            run_cycles(1 + ($urandom % 40));
            @(posedge clk); #1;
            sanity = 1'b1;
            #1;
            for (int g = 0; g < NCFG; g++) check("R1 R8", g, g[0] ? '0 : '1);
            #(10 * (1 + ($urandom % 3)));
            for (int g = 0; g < NCFG; g++) check("R1", g, g[0] ? '0 : '1);
            release_clear();
            #1;
            for (int g = 0; g < NCFG; g++) check("R8", g, g[0] ? '0 : '1);
        end

        // R7: long run across several wraps.
        run_cycles(70);
        finish_run();
    end

endmodule